// File: doc/BRIEF.md
# Auxiliary External Interrupt Control

This block adds two extra active-low external interrupt inputs to a small processor's special-function register space. A single 8-bit control register holds one nibble per channel. Each nibble has a trigger-type bit, a request flag, an enable bit and a priority bit. Software reaches the register through a whole-byte port and a single-bit port; the single-bit port uses a bit address range that starts at the register's own address.

Each pin first passes through a synchronizer with a falling-edge detector. In edge mode, a detected falling edge latches the request flag, and a service acknowledge from the interrupt controller clears it. In level mode, the synchronized pin itself forms the request, and the flag bit only reflects that pin.

The block presents a raw request, an enable and a priority level for each channel. Vectoring and arbitration take place in the interrupt controller that consumes these outputs.

Top module: `aux_extint_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 00h and every request, enable and priority output is 0. Reset also treats both pins as high, as if pulled up.
- R2: A byte write when `sfr_addr` equals C0h loads the register, and a byte read at C0h returns it. A byte write at any other address leaves the register unchanged, and a byte read at any other address returns 00h.
- R3: A bit write at bit address C0h+n (n = 0..7) changes only register bit n, and a bit read at C0h+n returns bit n. A bit write to an address outside C0h..C7h changes nothing, and a bit read outside that range returns 0.
- R4: Register bits [3:0] belong to channel 0 and bits [7:4] to channel 1. Inside each nibble, bit 0 is the type (1 = falling edge, 0 = low level), bit 1 is the flag, bit 2 is the enable and bit 3 is the priority (1 = high). The enable and priority outputs follow their bits, and they change only when software writes those bits.
- R5: In edge mode, a pin that is sampled high and then low after the two-flop synchronizer sets the flag. The flag and the request output go high on the third rising clock edge after the pin falls. A pin that stays low does not set the flag again.
- R6: In edge mode, a service acknowledge clears the flag and the request on the next clock edge, unless a new edge is detected in that same cycle.
- R7: In level mode, the request and the flag bit read back equal the inverted synchronized pin, two clock edges after the pin changes. Acknowledges and software writes to the flag have no effect in this mode.
- R8: When an edge is detected in the same cycle as a software write of 0 to the flag, the flag ends set.
- R9: In edge mode, software can set or clear the flag. A flag write is honoured only if the channel was already in edge mode before that write. Otherwise the flag stays 0, so a byte write of FFh from level mode reads back DDh.
- R10: When a byte write to C0h and a bit write to the register occur in the same cycle, the byte write wins. A bit write is applied when the same-cycle byte write targets another address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Byte access address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Byte read data (combinational) |
| bit_addr | input | 8 | Bit access address |
| bit_wr | input | 1 | Bit write strobe |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Bit read value (combinational) |
| pin_n | input | 2 | Asynchronous active-low interrupt pins |
| svc_ack | input | 2 | Per-channel service acknowledge |
| irq_req_o | output | 2 | Per-channel request |
| irq_en_o | output | 2 | Per-channel enable bit |
| irq_hi_o | output | 2 | Per-channel high-priority bit |

## Verification
The hardest case to reach from the ports is the collision between an edge detection and a software clear of the flag in one cycle. Because of the synchronizer and the edge detector, the pin must fall exactly three clock edges before the write commits. The stimulus drops the pin on a falling clock edge, lets two rising edges pass, and then presents the bit-clear so that it lands on the rising edge where the detector fires. A control case first clears the flag with the pin held steady, to show that the same write does clear it when no edge is present.

// File: rtl/aux_extint_pkg.sv
package aux_extint_pkg;

    localparam int NIB_W    = 4;
    localparam int POS_TYP  = 0;
    localparam int POS_FLAG = 1;
    localparam int POS_EN   = 2;
    localparam int POS_PRIO = 3;

    // One channel's control nibble, MSB first.
    typedef struct packed {
        logic prio;
        logic en;
        logic flag;
        logic typ;
    } ctl_nib_t;

    // Select between a held bit and a written bit.
    function automatic logic pick_bit(logic cur, logic mask, logic val);
        return mask ? val : cur;
    endfunction

endpackage

// File: rtl/aux_extint_sync.sv
module aux_extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic level_n,
    output logic fall
);
    // chain[STAGES-1:0] synchronizes, chain[STAGES] holds the prior sample.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-1:0], pin_n};
    end

    assign level_n = chain_q[STAGES-1];
    assign fall    = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/aux_extint_chan.sv
module aux_extint_chan
    import aux_extint_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NIB_W-1:0]      wr_mask,
    input  logic [NIB_W-1:0]      wr_val,
    input  logic                  fall,
    input  logic                  level_n,
    input  logic                  ack,
    output ctl_nib_t              view,
    output logic                  req,
    output logic                  en,
    output logic                  hi,
    output logic                  typ
);
    ctl_nib_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q.typ  <= pick_bit(ctl_q.typ,  wr_mask[POS_TYP],  wr_val[POS_TYP]);
            ctl_q.en   <= pick_bit(ctl_q.en,   wr_mask[POS_EN],   wr_val[POS_EN]);
            ctl_q.prio <= pick_bit(ctl_q.prio, wr_mask[POS_PRIO], wr_val[POS_PRIO]);
            if (!ctl_q.typ)              ctl_q.flag <= 1'b0;
            else if (fall)               ctl_q.flag <= 1'b1;
            else if (wr_mask[POS_FLAG])  ctl_q.flag <= wr_val[POS_FLAG];
            else if (ack)                ctl_q.flag <= 1'b0;
        end
    end

    always_comb begin
        view      = ctl_q;
        view.flag = ctl_q.typ ? ctl_q.flag : ~level_n;
    end

    assign req = view.flag;
    assign en  = ctl_q.en;
    assign hi  = ctl_q.prio;
    assign typ = ctl_q.typ;
endmodule

// File: rtl/aux_extint_sfr.sv
module aux_extint_sfr #(
    parameter logic [7:0] REG_ADDR = 8'hC0,
    parameter int         REG_W    = 8,
    localparam int        IDX_W    = $clog2(REG_W)
) (
    input  logic [7:0]       sfr_addr,
    input  logic             sfr_wr,
    input  logic [REG_W-1:0] sfr_wdata,
    input  logic [7:0]       bit_addr,
    input  logic             bit_wr,
    input  logic             bit_wdata,
    input  logic [REG_W-1:0] view,
    output logic [REG_W-1:0] wr_mask,
    output logic [REG_W-1:0] wr_val,
    output logic [REG_W-1:0] sfr_rdata,
    output logic             bit_rdata
);
    logic             byte_hit;
    logic             bit_hit;
    logic [7:0]       bit_off;
    logic [IDX_W-1:0] idx;

    assign byte_hit = (sfr_addr == REG_ADDR);
    assign bit_off  = bit_addr - REG_ADDR;
    assign bit_hit  = (bit_off < 8'(REG_W));
    assign idx      = bit_off[IDX_W-1:0];

    always_comb begin
        wr_mask = '0;
        wr_val  = '0;
        if (sfr_wr && byte_hit) begin
            wr_mask = '1;
            wr_val  = sfr_wdata;
        end else if (bit_wr && bit_hit) begin
            wr_mask[idx] = 1'b1;
            wr_val[idx]  = bit_wdata;
        end
    end

    assign sfr_rdata = byte_hit ? view : '0;
    assign bit_rdata = bit_hit ? view[idx] : 1'b0;
endmodule

// File: rtl/aux_extint_ctrl.sv
module aux_extint_ctrl
    import aux_extint_pkg::*;
#(
    parameter logic [7:0] REG_ADDR    = 8'hC0,
    parameter int         NUM_CH      = 2,
    parameter int         SYNC_STAGES = 2,
    localparam int        REG_W       = NIB_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [REG_W-1:0]  sfr_wdata,
    output logic [REG_W-1:0]  sfr_rdata,
    input  logic [7:0]        bit_addr,
    input  logic              bit_wr,
    input  logic              bit_wdata,
    output logic              bit_rdata,
    input  logic [NUM_CH-1:0] pin_n,
    input  logic [NUM_CH-1:0] svc_ack,
    output logic [NUM_CH-1:0] irq_req_o,
    output logic [NUM_CH-1:0] irq_en_o,
    output logic [NUM_CH-1:0] irq_hi_o
);
    logic [REG_W-1:0]  wr_mask;
    logic [REG_W-1:0]  wr_val;
    logic [REG_W-1:0]  view_w;
    logic [NUM_CH-1:0] fall_w;
    logic [NUM_CH-1:0] level_w;
    logic [NUM_CH-1:0] typ_w;

    aux_extint_sfr #(.REG_ADDR(REG_ADDR), .REG_W(REG_W)) sfr_i (
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .bit_addr  (bit_addr),
        .bit_wr    (bit_wr),
        .bit_wdata (bit_wdata),
        .view      (view_w),
        .wr_mask   (wr_mask),
        .wr_val    (wr_val),
        .sfr_rdata (sfr_rdata),
        .bit_rdata (bit_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctl_nib_t nib_view;

        aux_extint_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk     (clk),
            .rst     (rst),
            .pin_n   (pin_n[c]),
            .level_n (level_w[c]),
            .fall    (fall_w[c])
        );

        aux_extint_chan chan_i (
            .clk     (clk),
            .rst     (rst),
            .wr_mask (wr_mask[c*NIB_W +: NIB_W]),
            .wr_val  (wr_val[c*NIB_W +: NIB_W]),
            .fall    (fall_w[c]),
            .level_n (level_w[c]),
            .ack     (svc_ack[c]),
            .view    (nib_view),
            .req     (irq_req_o[c]),
            .en      (irq_en_o[c]),
            .hi      (irq_hi_o[c]),
            .typ     (typ_w[c])
        );

        assign view_w[c*NIB_W +: NIB_W] = nib_view;
    end
endmodule

// File: rtl/aux_extint_chk.sv
module aux_extint_chk
    import aux_extint_pkg::*;
#(
    parameter int  NUM_CH = 2,
    localparam int REG_W  = NIB_W * NUM_CH
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] typ,
    input logic [NUM_CH-1:0] fall,
    input logic [NUM_CH-1:0] level_n,
    input logic [NUM_CH-1:0] req,
    input logic [NUM_CH-1:0] ack,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] hi,
    input logic [REG_W-1:0]  wr_mask
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (req == '0 && en == '0 && hi == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_en_by_write_R4: assert property (@(posedge clk) disable iff (rst)
            !$stable(en[c]) |-> $past(wr_mask[c*NIB_W+POS_EN]));

        assert_hi_by_write_R4: assert property (@(posedge clk) disable iff (rst)
            !$stable(hi[c]) |-> $past(wr_mask[c*NIB_W+POS_PRIO]));

        assert_edge_sets_R5: assert property (@(posedge clk) disable iff (rst)
            typ[c] && fall[c] && !wr_mask[c*NIB_W+POS_TYP] |=> req[c]);

        assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
            typ[c] && ack[c] && !fall[c] && !wr_mask[c*NIB_W+POS_TYP]
            && !wr_mask[c*NIB_W+POS_FLAG] |=> !req[c]);

        assert_level_req_R7: assert property (@(posedge clk) disable iff (rst)
            !typ[c] && $fell(level_n[c]) |-> req[c]);

        assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
            typ[c] && fall[c] && wr_mask[c*NIB_W+POS_FLAG]
            && !wr_mask[c*NIB_W+POS_TYP] |=> req[c]);
    end
endmodule

bind aux_extint_ctrl aux_extint_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .typ     (typ_w),
    .fall    (fall_w),
    .level_n (level_w),
    .req     (irq_req_o),
    .ack     (svc_ack),
    .en      (irq_en_o),
    .hi      (irq_hi_o),
    .wr_mask (wr_mask)
);

// File: tb/aux_extint_ctrl_tb_top.sv
module aux_extint_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [7:0] bit_addr = 8'h00;
    logic       bit_wr = 1'b0;
    logic       bit_wdata = 1'b0;
    logic       bit_rdata;
    logic [1:0] pin_n = 2'b11;
    logic [1:0] svc_ack = 2'b00;
    logic [1:0] irq_req_o, irq_en_o, irq_hi_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    aux_extint_ctrl dut_i (
        .clk(clk), .rst(rst),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .bit_addr(bit_addr), .bit_wr(bit_wr), .bit_wdata(bit_wdata), .bit_rdata(bit_rdata),
        .pin_n(pin_n), .svc_ack(svc_ack),
        .irq_req_o(irq_req_o), .irq_en_o(irq_en_o), .irq_hi_o(irq_hi_o)
    );

    // op(24) 1=write, addr(23:16), data(15:8), expected read(7:0)
    localparam int NVEC = 11;
    localparam logic [24:0] VEC [0:NVEC-1] = '{
        {1'b1, 8'hC0, 8'hFF, 8'h00},
        {1'b0, 8'hC0, 8'h00, 8'hDD},
        {1'b1, 8'hC0, 8'hFF, 8'h00},
        {1'b0, 8'hC0, 8'h00, 8'hFF},
        {1'b1, 8'hC0, 8'h00, 8'h00},
        {1'b0, 8'hC0, 8'h00, 8'h00},
        {1'b1, 8'hC0, 8'hA5, 8'h00},
        {1'b0, 8'hC0, 8'h00, 8'h85},
        {1'b1, 8'hC1, 8'hFF, 8'h00},
        {1'b0, 8'hC1, 8'h00, 8'h00},
        {1'b1, 8'hC0, 8'h5A, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling clock edge.
    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic bwr(input logic [7:0] a, input logic d);
        bit_addr = a; bit_wdata = d; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1 d = sfr_rdata;
    endtask

    task automatic brd(input logic [7:0] a, output logic d);
        bit_addr = a;
        #1 d = bit_rdata;
    endtask

    task automatic ack(input logic [1:0] m);
        svc_ack = m;
        @(negedge clk);
        svc_ack = 2'b00;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ticks(1);
        // R1 reset state
        rd(8'hC0, rv); chk("R1 reg", rv, 8'h00);
        chk("R1 outputs", {2'b00, irq_req_o, irq_en_o, irq_hi_o}, 8'h00);

        // R2 / R9 table walk (pins high)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][23:16], rv);
                chk("R2 table", rv, VEC[i][7:0]);
            end
        end
        rd(8'hC0, rv); chk("R2 after 5A", rv, 8'h58);

        // R3 bit access
        wr(8'hC0, 8'h00);
        bwr(8'hC2, 1'b1);
        rd(8'hC0, rv); chk("R3 bit set", rv, 8'h04);
        chk("R3 en out", {6'b0, irq_en_o}, 8'h01);
        brd(8'hC2, b); chk("R3 bit read 1", {7'b0, b}, 8'h01);
        brd(8'hC3, b); chk("R3 bit read 0", {7'b0, b}, 8'h00);
        bwr(8'hC8, 1'b1);
        bwr(8'hBF, 1'b1);
        rd(8'hC0, rv); chk("R3 out of range write", rv, 8'h04);
        brd(8'hC8, b); chk("R3 out of range read", {7'b0, b}, 8'h00);

        // R4 enable/priority outputs
        wr(8'hC0, 8'h88);
        chk("R4 prio", {2'b0, irq_en_o, 2'b0, irq_hi_o}, 8'h03);
        wr(8'hC0, 8'h44);
        chk("R4 enable", {2'b0, irq_en_o, 2'b0, irq_hi_o}, 8'h30);

        // R5 edge detection latency
        wr(8'hC0, 8'h01);
        pin_n[0] = 1'b0;
        ticks(2);
        chk("R5 not yet", {6'b0, irq_req_o}, 8'h00);
        ticks(1);
        chk("R5 req", {6'b0, irq_req_o}, 8'h01);
        rd(8'hC0, rv); chk("R5 flag", rv, 8'h03);

        // R6 acknowledge, no retrigger while pin stays low
        ack(2'b01);
        chk("R6 req cleared", {6'b0, irq_req_o}, 8'h00);
        ticks(4);
        rd(8'hC0, rv); chk("R6 no retrigger", rv, 8'h01);

        // R9 software flag control in edge mode
        bwr(8'hC1, 1'b1);
        rd(8'hC0, rv); chk("R9 sw set", rv, 8'h03);
        chk("R9 req", {6'b0, irq_req_o}, 8'h01);
        bwr(8'hC1, 1'b0);
        rd(8'hC0, rv); chk("R9 sw clear", rv, 8'h01);

        // R7 level mode
        pin_n[0] = 1'b1;
        ticks(4);
        wr(8'hC0, 8'h00);
        pin_n[1] = 1'b0;
        ticks(2);
        chk("R7 level req", {6'b0, irq_req_o}, 8'h02);
        rd(8'hC0, rv); chk("R7 level flag", rv, 8'h20);
        ack(2'b10);
        chk("R7 ack ignored", {6'b0, irq_req_o}, 8'h02);
        bwr(8'hC5, 1'b0);
        rd(8'hC0, rv); chk("R7 write ignored", rv, 8'h20);
        pin_n[1] = 1'b1;
        ticks(2);
        chk("R7 level release", {6'b0, irq_req_o}, 8'h00);

        // R8 edge detection vs software clear in the same cycle
        wr(8'hC0, 8'h01);
        pin_n[0] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bit_addr = 8'hC1; bit_wdata = 1'b0; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
        rd(8'hC0, rv); chk("R8 set wins", rv, 8'h03);
        bwr(8'hC1, 1'b0);
        rd(8'hC0, rv); chk("R8 control clear", rv, 8'h01);

        // R10 byte vs bit write in the same cycle
        pin_n[0] = 1'b1;
        ticks(4);
        sfr_addr = 8'hC0; sfr_wdata = 8'h00; sfr_wr = 1'b1;
        bit_addr = 8'hC2; bit_wdata = 1'b1; bit_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; bit_wr = 1'b0;
        rd(8'hC0, rv); chk("R10 byte wins", rv, 8'h00);
        sfr_addr = 8'hC1; sfr_wdata = 8'hFF; sfr_wr = 1'b1;
        bit_addr = 8'hC2; bit_wdata = 1'b1; bit_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; bit_wr = 1'b0;
        rd(8'hC0, rv); chk("R10 bit applies", rv, 8'h04);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule